// File: doc/BRIEF.md
# Debug Register Access Chain

This block is a serial data-register chain behind a test access port. It gives a debugger read and write access to a small file of debug control registers: breakpoint controls, watchpoint controls and a vector-catch register. Each scan carries one 40-bit frame. The frame holds a request flag, a 32-bit data word and a 7-bit register address. The access is pipelined by one request. At Update-DR the request shifted in is queued. The next scan's Capture-DR then loads the address and data of that finished access for shifting out.

An access takes `ACC_LAT` clock cycles to complete after Update-DR. When a capture happens before the access has completed, the first shifted-out bit (Ready) reads 0 and the request shifted in by that scan is discarded, so the host repeats the same scan until Ready reads 1. To collect the last result, the host sends a read of address 0. What the register values mean for breakpoint matching is outside this block. The TAP controller itself is also outside it: the block sees only qualified capture, shift and update strobes, clocked by `clk`.

Top module: `dbg_sc_chain`

## Requirements
- R1: A frame is 40 bits, shifted least significant first. Bit 0 is the request flag (1 = write, 0 = read). Bits 32..1 hold the data word, least significant bit first. Bits 39..33 hold the register address.
- R2: Bit 0 of the shifted-out frame is Ready. It is 1 when no access is pending at Capture-DR and 0 otherwise.
- R3: With Ready 1, the address and data shifted out belong to the last request accepted before this scan.
- R4: For an accepted write, the data returned by the following scan equals the written value.
- R5: A read returns the register contents. Address 0x07 is vector catch, addresses 0x50..0x55 are breakpoint controls and addresses 0x70..0x71 are watchpoint controls.
- R6: Any other address reads as zero and ignores writes.
- R7: A scan whose capture comes within `ACC_LAT` cycles of the previous accepted update returns Ready 0 together with the older result, and its request is not applied.
- R8: A read of address 0 with data 0 returns the last result and changes no register.
- R9: Writing zero to a mapped register clears it.
- R10: After reset all registers hold zero, and the first scan returns Ready 1, address 0 and data 0.
- R11: While `chain_sel` is low, the strobes have no effect and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel | input | 1 | This chain is selected by the instruction and chain-select logic |
| tap_capture | input | 1 | Capture-DR strobe |
| tap_shift | input | 1 | Shift-DR strobe |
| tap_update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |

## Verification
The bench builds the block with its defaults: six breakpoint controls, two watchpoint controls and a two-cycle access latency. With the 7-bit address, this lets a sweep write and read back every one of the 128 addresses, so every mapped slot and every unmapped hole is reached. The two-cycle latency lets a back-to-back scan with no idle cycle land in the busy window, which exercises the Ready-0 discard path and its retry.

// File: rtl/dbgsc_pkg.sv
package dbgsc_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int FRAME_W = 1 + DATA_W + ADDR_W;
    localparam int SLOT_W  = 5;

    localparam int VC_ADDR = 7;
    localparam int BP_BASE = 'h50;
    localparam int WP_BASE = 'h70;

    // bit 0 first on the wire, address last
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              flag;
    } frame_t;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } slot_t;

    // breakpoints first, then watchpoints, vector catch last
    function automatic slot_t map_addr(input logic [ADDR_W-1:0] a,
                                       input int nbp, input int nwp);
        slot_t s;
        int    ai;
        ai    = int'(a);
        s.hit = 1'b0;
        s.idx = '0;
        if (ai == VC_ADDR) begin
            s.hit = 1'b1;
            s.idx = SLOT_W'(nbp + nwp);
        end else if (ai >= BP_BASE && ai < BP_BASE + nbp) begin
            s.hit = 1'b1;
            s.idx = SLOT_W'(ai - BP_BASE);
        end else if (ai >= WP_BASE && ai < WP_BASE + nwp) begin
            s.hit = 1'b1;
            s.idx = SLOT_W'(nbp + ai - WP_BASE);
        end
        return s;
    endfunction
endpackage

// File: rtl/dbgsc_shifter.sv
module dbgsc_shifter
    import dbgsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cap,
    input  logic   shift,
    input  frame_t load,
    input  logic   tdi,
    output frame_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (cap) begin
            q <= load;
        end else if (shift) begin
            q <= frame_t'({tdi, q[FRAME_W-1:1]});
        end
    end
endmodule

// File: rtl/dbgsc_regfile.sv
module dbgsc_regfile
    import dbgsc_pkg::*;
#(
    parameter int NUM_BP = 6,
    parameter int NUM_WP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hit
);
    localparam int NREG = NUM_BP + NUM_WP + 1;

    logic [DATA_W-1:0]      regs [NREG];
    logic [NREG*DATA_W-1:0] flat;
    slot_t                  slot;

    assign slot = map_addr(addr, NUM_BP, NUM_WP);
    assign hit  = slot.hit;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (acc_en && acc_wr && slot.hit && slot.idx == SLOT_W'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (slot.hit && slot.idx == SLOT_W'(i)) rdata = regs[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign flat[g*DATA_W +: DATA_W] = regs[g];
    end

    // R6
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && acc_wr && !hit) |=> $stable(flat));
endmodule

// File: rtl/dbgsc_seq.sv
module dbgsc_seq
    import dbgsc_pkg::*;
#(
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  frame_t            req,
    input  logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              acc_en,
    output frame_t            pend,
    output logic [ADDR_W-1:0] res_addr,
    output logic [DATA_W-1:0] res_data
);
    localparam int CW = $clog2(ACC_LAT + 1);

    logic [CW-1:0] cnt;

    assign busy   = (cnt != '0);
    assign acc_en = (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pend     <= '0;
            res_addr <= '0;
            res_data <= '0;
        end else begin
            if (fire) begin
                pend <= req;
                cnt  <= CW'(ACC_LAT);
            end else if (busy) begin
                cnt <= cnt - CW'(1);
            end
            if (acc_en) begin
                res_addr <= pend.addr;
                res_data <= pend.flag ? pend.data : rdata;
            end
        end
    end

    // R7
    req_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> !busy);
endmodule

// File: rtl/dbg_sc_chain.sv
module dbg_sc_chain
    import dbgsc_pkg::*;
#(
    parameter int NUM_BP  = 6,
    parameter int NUM_WP  = 2,
    parameter int ACC_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic chain_sel,
    input  logic tap_capture,
    input  logic tap_shift,
    input  logic tap_update,
    input  logic tdi,
    output logic tdo
);
    logic              cap_en, shift_en, upd_en, fire;
    logic              cap_ready;
    logic              busy, acc_en, hit;
    frame_t            sr, load, pend;
    logic [ADDR_W-1:0] res_addr;
    logic [DATA_W-1:0] res_data, rdata;

    assign cap_en   = chain_sel && tap_capture;
    assign shift_en = chain_sel && tap_shift;
    assign upd_en   = chain_sel && tap_update;
    assign fire     = upd_en && cap_ready;

    // the ready bit seen at capture decides whether the following update counts
    always_ff @(posedge clk) begin
        if (rst)         cap_ready <= 1'b0;
        else if (cap_en) cap_ready <= !busy;
        else if (upd_en) cap_ready <= 1'b0;
    end

    assign load = '{addr: res_addr, data: res_data, flag: !busy};
    assign tdo  = chain_sel && sr.flag;

    dbgsc_shifter u_shift (
        .clk(clk), .rst(rst), .cap(cap_en), .shift(shift_en),
        .load(load), .tdi(tdi), .q(sr)
    );

    dbgsc_seq #(.ACC_LAT(ACC_LAT)) u_seq (
        .clk(clk), .rst(rst), .fire(fire), .req(sr), .rdata(rdata),
        .busy(busy), .acc_en(acc_en), .pend(pend),
        .res_addr(res_addr), .res_data(res_data)
    );

    dbgsc_regfile #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_rf (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(pend.flag),
        .addr(pend.addr), .wdata(pend.data), .rdata(rdata), .hit(hit)
    );

    // R2
    busy_ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_en && busy) |=> !sr.flag);

    // R4
    write_echo_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_en && pend.flag && hit) |=> (rdata == res_data));

    // R11
    deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!chain_sel && !busy) |=> !busy);
endmodule

// File: tb/tb_dbg_sc_chain.sv
module tb_dbg_sc_chain;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chain_sel = 1'b0, tap_capture = 1'b0, tap_shift = 1'b0, tap_update = 1'b0, tdi = 1'b0;
    logic tdo;

    int checks = 0;
    int fails  = 0;

    logic [31:0] model [128];
    logic [6:0]  prev_a;
    logic [31:0] prev_d;

    always #10 clk = ~clk;

    dbg_sc_chain dut (
        .clk(clk), .rst(rst), .chain_sel(chain_sel), .tap_capture(tap_capture),
        .tap_shift(tap_shift), .tap_update(tap_update), .tdi(tdi), .tdo(tdo)
    );

    function automatic bit mapped(input int a);
        return a == 7 || (a >= 80 && a < 86) || (a >= 112 && a < 114);
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic scan(input bit sel, input int gap, input logic wr,
                        input logic [31:0] d, input logic [6:0] a,
                        output logic rdy, output logic [31:0] od, output logic [6:0] oa);
        logic [39:0] fin, fout;
        fin = {a, d, wr};
        repeat (gap) @(negedge clk);
        @(negedge clk);
        chain_sel = sel; tap_capture = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            tap_capture = 1'b0; tap_shift = 1'b1; tdi = fin[i];
            fout[i] = tdo;
        end
        @(negedge clk);
        tap_shift = 1'b0; tap_update = 1'b1;
        @(negedge clk);
        tap_update = 1'b0; chain_sel = 1'b0;
        rdy = fout[0]; od = fout[32:1]; oa = fout[39:33];
    endtask

    // accepted access: check returned previous result, then advance model
    task automatic acc(input string tag, input logic wr, input logic [31:0] d, input logic [6:0] a);
        logic r; logic [31:0] od; logic [6:0] oa;
        scan(1'b1, 2, wr, d, a, r, od, oa);
        chk("R2", {39'd0, r}, 40'd1);
        chk("R3", {33'd0, oa}, {33'd0, prev_a});
        chk(tag, {8'd0, od}, {8'd0, prev_d});
        if (wr && mapped(int'(a))) model[a] = d;
        prev_a = a;
        prev_d = wr ? d : (mapped(int'(a)) ? model[a] : 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic r; logic [31:0] od; logic [6:0] oa;
        logic [6:0] sa; logic [31:0] sd;
        for (int i = 0; i < 128; i++) model[i] = 32'd0;
        prev_a = '0; prev_d = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R11", {39'd0, tdo}, 40'd0);
        scan(1'b1, 2, 1'b0, 32'd0, 7'd0, r, od, oa);
        chk("R10", {r, od, oa}, {1'b1, 32'd0, 7'd0});

        // R1 bit order of data and address
        acc("R1", 1'b1, 32'h0000_0001, 7'h50);
        acc("R1", 1'b1, 32'h8000_0000, 7'h71);
        acc("R4", 1'b0, 32'd0, 7'h50);
        acc("R1", 1'b0, 32'd0, 7'h71);

        // write sweep over all addresses, then read sweep
        for (int a = 0; a < 128; a++)
            acc("R4", 1'b1, 32'h9E37_79B9 * (a + 1), 7'(a));
        for (int a = 0; a < 128; a++)
            acc(mapped(a) ? "R5" : "R6", 1'b0, 32'd0, 7'(a));
        acc("R5", 1'b0, 32'd0, 7'h07);

        // R8 flush returns last result, twice gives the flush itself
        acc("R8", 1'b0, 32'd0, 7'd0);
        acc("R8", 1'b0, 32'd0, 7'd0);
        chk("R8", {8'd0, model[7]}, {8'd0, 32'h9E37_79B9 * 8});

        // R7 busy: back-to-back scan is refused and discarded
        sa = prev_a; sd = prev_d;
        acc("R4", 1'b1, 32'hCAFE_0051, 7'h51);
        scan(1'b1, 0, 1'b1, 32'h1234_5678, 7'h52, r, od, oa);
        chk("R7", {r, od, oa}, {1'b0, sd, sa});
        acc("R7", 1'b0, 32'd0, 7'h52);
        acc("R7", 1'b0, 32'd0, 7'd0);

        // R11 deselected scan leaves state alone
        scan(1'b0, 2, 1'b1, 32'hDEAD_BEEF, 7'h70, r, od, oa);
        chk("R11", {r, od, oa}, 40'd0);
        acc("R11", 1'b0, 32'd0, 7'h70);
        acc("R11", 1'b0, 32'd0, 7'd0);

        // R9 clear all mapped registers, read them back
        for (int a = 0; a < 128; a++)
            if (mapped(a)) acc("R9", 1'b1, 32'd0, 7'(a));
        for (int a = 0; a < 128; a++)
            if (mapped(a)) acc("R9", 1'b0, 32'd0, 7'(a));
        acc("R9", 1'b0, 32'd0, 7'd0);
        chk("R9", {8'd0, model[80]}, 40'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule